// File: doc/BRIEF.md
# Oscillator Tuning Word Decoder with FSK Keying

This block holds the digital frequency settings of a switched-capacitor oscillator and drives that oscillator's capacitor-bank switch lines. There are three carrier banks (coarse, medium and fine) and a separate deviation bank. A four-wire serial configuration port, clocked by a host, writes one register per frame. Only a complete frame loads a register. A frame that is cut short or runs too long leaves every register as it was, so the banks never see a half-written code.

Each carrier word is expanded to a thermometer code, so a code step upward only ever adds capacitance, and the tuning stays monotonic. The fine word uses a two-level expansion: its upper five bits pick how many of 32 identical columns are fully on, and its lower three bits pick how many elements of the next column are on.

The stored deviation word is ANDed bit by bit with a unipolar NRZ data input. The oscillator is therefore keyed between the carrier and the carrier plus the deviation. A transmit-enable input holds the deviation lines off. Calibration proceeds in two steps. First the deviation word stays zero while the carrier is trimmed. Then the deviation word is written.

Top module: `dco_tune_dec`

## Requirements
- R1: After reset, every switch output (coarse, medium, fine and deviation) is all zeros.
- R2: A frame starts when cfg_cs_n goes low. It carries 10 bits, most significant bit first, each sampled on a rising cfg_sclk edge. The first 2 bits select the target register (0 = coarse, 1 = medium, 2 = fine, 3 = deviation) and the last 8 bits are the data. The frame takes effect when cfg_cs_n returns high, and the outputs show it by the fourth rising clk edge after that.
- R3: A frame with fewer or more than 10 bits is discarded, and no register changes.
- R4: While a frame is in progress, no switch output changes.
- R5: The coarse output has 63 lines. Line i is on exactly when i is less than the coarse code, which is the low 6 data bits; data bits 7:6 are ignored.
- R6: The medium output has 63 lines. Line i is on exactly when i is less than the medium code, which is the low 6 data bits.
- R7: The fine output has 255 lines, and line k = 8*column + position. A line is on when its column index is below data bits 7:3, or when its column equals data bits 7:3 and its position is below data bits 2:0. This makes line k on exactly when k is less than the 8-bit code.
- R8: The deviation output equals the stored 8-bit deviation word when tx_en and tx_data are both 1, and is zero otherwise. It is updated on the first rising clk edge after the inputs change.
- R9: While tx_en is 0, the deviation output is zero whatever tx_data and the deviation word are.
- R10: Raising a carrier code never turns off a line that was on.
- R11: Deviation writes and tx_data activity leave the carrier outputs unchanged. With a zero deviation word, the deviation output stays zero while data toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sclk | input | 1 | Serial configuration clock, oversampled by clk |
| cfg_cs_n | input | 1 | Serial frame select, active low |
| cfg_mosi | input | 1 | Serial configuration data |
| tx_en | input | 1 | Transmit enable; low forces the deviation lines off |
| tx_data | input | 1 | Unipolar NRZ modulation data |
| coarse_sw | output | 63 | Coarse bank thermometer switch lines |
| medium_sw | output | 63 | Medium bank thermometer switch lines |
| fine_sw | output | 255 | Fine bank two-level thermometer switch lines |
| dev_sw | output | 8 | Deviation bank switch lines after data gating |

## Verification
A configuration write passes through a two-flop synchronizer, an edge detector, the register and the output flop. Its result is therefore due on the fourth clk edge after cfg_cs_n rises. The bench waits six clock periods after raising cfg_cs_n before it samples, so the checks land after that edge. The deviation path has one flop, so every tx_en or tx_data change is driven on a falling clk edge and checked at the next falling edge. Outputs are compared against the previous expected value partway through a frame, and again after malformed frames, which shows that nothing moves before the chip-select edge of a valid frame.

// File: rtl/dtd_pkg.sv
package dtd_pkg;
   localparam int SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_COARSE = 2'd0,
      SEL_MEDIUM = 2'd1,
      SEL_FINE   = 2'd2,
      SEL_DEV    = 2'd3
   } bank_sel_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/dtd_ser_rx.sv
module dtd_ser_rx #(
   parameter int FRAME_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk,
   input  logic               cs_n,
   input  logic               mosi,
   output logic               word_stb,
   output logic [FRAME_W-1:0] word
);
   localparam int CNT_W = $clog2(FRAME_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

   logic [1:0] sclk_s, cs_s, mosi_s;
   logic       sclk_d, cs_d;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_s <= '0;
         cs_s   <= 2'b11;
         mosi_s <= '0;
         sclk_d <= 1'b0;
         cs_d   <= 1'b1;
      end else begin
         sclk_s <= {sclk_s[0], sclk};
         cs_s   <= {cs_s[0], cs_n};
         mosi_s <= {mosi_s[0], mosi};
         sclk_d <= sclk_s[1];
         cs_d   <= cs_s[1];
      end
   end

   wire sclk_rise = sclk_s[1] & ~sclk_d;
   wire cs_fall   = ~cs_s[1] & cs_d;
   wire cs_rise   = cs_s[1] & ~cs_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         word <= '0;
      end else if (cs_fall) begin
         cnt <= '0;
      end else if (!cs_s[1] && sclk_rise) begin
         word <= {word[FRAME_W-2:0], mosi_s[1]};
         if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
      end
   end

   assign word_stb = cs_rise && (cnt == CNT_FULL);
endmodule

// File: rtl/dtd_therm.sv
module dtd_therm #(
   parameter int CODE_W = 6
) (
   input  logic [CODE_W-1:0]      code,
   output logic [2**CODE_W-2:0]   lines
);
   localparam int LINES = 2**CODE_W - 1;

   generate
      if (CODE_W < 1 || CODE_W > 10) begin : g_bad_w
         $error("dtd_therm: CODE_W out of range");
      end
   endgenerate

   for (genvar i = 0; i < LINES; i++) begin : g_line
      assign lines[i] = (code > CODE_W'(i));
   end
endmodule

// File: rtl/dtd_fine_therm.sv
module dtd_fine_therm #(
   parameter int COL_W = 5,
   parameter int POS_W = 3
) (
   input  logic [COL_W+POS_W-1:0]      code,
   output logic [2**(COL_W+POS_W)-2:0] lines
);
   localparam int CODE_W = COL_W + POS_W;
   localparam int COLS   = 2**COL_W;
   localparam int ROWS   = 2**POS_W;
   localparam int LINES  = 2**CODE_W - 1;

   generate
      if (COL_W < 1 || POS_W < 1 || CODE_W > 10) begin : g_bad_w
         $error("dtd_fine_therm: split widths out of range");
      end
   endgenerate

   wire [COL_W-1:0] col = code[CODE_W-1:POS_W];
   wire [POS_W-1:0] pos = code[POS_W-1:0];

   logic [COLS*ROWS-1:0] grid;
   logic [COLS-1:0]      col_full, col_part;
   logic [ROWS-1:0]      row_on;

   for (genvar p = 0; p < ROWS; p++) begin : g_row
      assign row_on[p] = (pos > POS_W'(p));
   end

   for (genvar c = 0; c < COLS; c++) begin : g_col
      assign col_full[c] = (col > COL_W'(c));
      assign col_part[c] = (col == COL_W'(c));
      for (genvar p = 0; p < ROWS; p++) begin : g_el
         assign grid[c*ROWS+p] = col_full[c] | (col_part[c] & row_on[p]);
      end
   end

   assign lines = grid[LINES-1:0];

   logic unused_top;
   assign unused_top = grid[COLS*ROWS-1];
endmodule

// File: rtl/dco_tune_dec.sv
module dco_tune_dec #(
   parameter int COARSE_W       = 6,
   parameter int MEDIUM_W       = 6,
   parameter int FINE_COL_W     = 5,
   parameter int FINE_POS_W     = 3,
   parameter int DEV_W          = 8,
   parameter bit FINE_TWO_LEVEL = 1'b1
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   cfg_sclk,
   input  logic                                   cfg_cs_n,
   input  logic                                   cfg_mosi,
   input  logic                                   tx_en,
   input  logic                                   tx_data,
   output logic [2**COARSE_W-2:0]                 coarse_sw,
   output logic [2**MEDIUM_W-2:0]                 medium_sw,
   output logic [2**(FINE_COL_W+FINE_POS_W)-2:0]  fine_sw,
   output logic [DEV_W-1:0]                       dev_sw
);
   import dtd_pkg::*;

   localparam int FINE_W  = FINE_COL_W + FINE_POS_W;
   localparam int DATA_W  = max_of(max_of(COARSE_W, MEDIUM_W), max_of(FINE_W, DEV_W));
   localparam int FRAME_W = SEL_W + DATA_W;
   localparam int C_LINES = 2**COARSE_W - 1;
   localparam int M_LINES = 2**MEDIUM_W - 1;
   localparam int F_LINES = 2**FINE_W - 1;

   generate
      if (COARSE_W > 8 || MEDIUM_W > 8 || FINE_W > 10 || DEV_W > 16) begin : g_bad_cfg
         $error("dco_tune_dec: bank width parameters out of range");
      end
   endgenerate

   logic               wr_stb;
   logic [FRAME_W-1:0] wr_word;

   dtd_ser_rx #(.FRAME_W(FRAME_W)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .sclk(cfg_sclk), .cs_n(cfg_cs_n), .mosi(cfg_mosi),
      .word_stb(wr_stb), .word(wr_word)
   );

   bank_sel_e         wr_sel;
   logic [DATA_W-1:0] wr_data;
   assign wr_sel  = bank_sel_e'(wr_word[FRAME_W-1 -: SEL_W]);
   assign wr_data = wr_word[DATA_W-1:0];

   logic [COARSE_W-1:0] coarse_q;
   logic [MEDIUM_W-1:0] medium_q;
   logic [FINE_W-1:0]   fine_q;
   logic [DEV_W-1:0]    dev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coarse_q <= '0;
         medium_q <= '0;
         fine_q   <= '0;
         dev_q    <= '0;
      end else if (wr_stb) begin
         unique case (wr_sel)
            SEL_COARSE: coarse_q <= wr_data[COARSE_W-1:0];
            SEL_MEDIUM: medium_q <= wr_data[MEDIUM_W-1:0];
            SEL_FINE:   fine_q   <= wr_data[FINE_W-1:0];
            SEL_DEV:    dev_q    <= wr_data[DEV_W-1:0];
         endcase
      end
   end

   logic [C_LINES-1:0] coarse_d;
   logic [M_LINES-1:0] medium_d;
   logic [F_LINES-1:0] fine_d;

   dtd_therm #(.CODE_W(COARSE_W)) u_coarse (.code(coarse_q), .lines(coarse_d));
   dtd_therm #(.CODE_W(MEDIUM_W)) u_medium (.code(medium_q), .lines(medium_d));

   generate
      if (FINE_TWO_LEVEL) begin : g_fine_split
         dtd_fine_therm #(.COL_W(FINE_COL_W), .POS_W(FINE_POS_W)) u_fine (
            .code(fine_q), .lines(fine_d));
      end else begin : g_fine_flat
         dtd_therm #(.CODE_W(FINE_W)) u_fine (.code(fine_q), .lines(fine_d));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coarse_sw <= '0;
         medium_sw <= '0;
         fine_sw   <= '0;
         dev_sw    <= '0;
      end else begin
         coarse_sw <= coarse_d;
         medium_sw <= medium_d;
         fine_sw   <= fine_d;
         dev_sw    <= dev_q & {DEV_W{tx_en & tx_data}};
      end
   end

   // Thermometer shape on every carrier bank: ones contiguous from line 0
   p_thermo_coarse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((coarse_sw + 1'b1) & coarse_sw) == '0)
      else $error("coarse lines not thermometer");
   p_thermo_medium_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((medium_sw + 1'b1) & medium_sw) == '0)
      else $error("medium lines not thermometer");
   p_thermo_fine_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((fine_sw + 1'b1) & fine_sw) == '0)
      else $error("fine lines not thermometer");

   // Outputs hold unless a completed frame was just accepted
   p_hold_no_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb ##1 !wr_stb |=> $stable(coarse_sw) && $stable(medium_sw) && $stable(fine_sw))
      else $error("carrier lines moved without a frame");

   // Transmit enable low keeps deviation lines off
   p_dev_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> dev_sw == '0)
      else $error("deviation lines on while disabled");

   // Deviation lines never exceed the stored word
   p_dev_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (dev_sw & ~$past(dev_q)) == '0)
      else $error("deviation line on outside stored word");

   // A larger coarse code never drops a line
   p_mono_coarse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (coarse_d & coarse_sw) == coarse_sw || (coarse_d & coarse_sw) == coarse_d)
      else $error("coarse decode not ordered");
endmodule

// File: tb/sim_dco_tune_dec.sv
module sim_dco_tune_dec;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_sclk = 1'b0, cfg_cs_n = 1'b1, cfg_mosi = 1'b0;
   logic tx_en = 1'b0, tx_data = 1'b0;
   logic [62:0]  coarse_sw, medium_sw;
   logic [254:0] fine_sw;
   logic [7:0]   dev_sw;

   int n_run = 0, n_fail = 0;

   always #10 clk = ~clk;

   dco_tune_dec u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_sclk(cfg_sclk), .cfg_cs_n(cfg_cs_n), .cfg_mosi(cfg_mosi),
      .tx_en(tx_en), .tx_data(tx_data),
      .coarse_sw(coarse_sw), .medium_sw(medium_sw),
      .fine_sw(fine_sw), .dev_sw(dev_sw)
   );

   function automatic logic [254:0] therm(input int code);
      logic [254:0] t = '0;
      for (int i = 0; i < 255; i++) t[i] = (i < code);
      return t;
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [254:0] act, input logic [254:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_out(input logic b);
      cfg_mosi = b; cfg_sclk = 1'b0; ticks(3);
      cfg_sclk = 1'b1; ticks(3);
      cfg_sclk = 1'b0;
   endtask

   task automatic frame(input logic [1:0] sel, input logic [7:0] data, input int nbits);
      logic [9:0] w = {sel, data};
      cfg_cs_n = 1'b0; ticks(3);
      for (int i = 0; i < nbits; i++) bit_out(i < 10 ? w[9-i] : 1'b1);
      ticks(3);
      cfg_cs_n = 1'b1; ticks(6);
   endtask

   logic [254:0] prev_c, prev_m, prev_f;

   initial begin
      ticks(3);
      rst_n = 1'b1;
      ticks(2);
      // R1 reset state
      chk(coarse_sw == '0 && medium_sw == '0 && fine_sw == '0 && dev_sw == '0,
          "R1 reset", 255'(coarse_sw), '0);

      // R2 R5 R10: coarse sweep, ascending
      prev_c = '0;
      for (int c = 0; c < 64; c++) begin
         frame(2'd0, 8'(c), 10);
         chk(255'(coarse_sw) == therm(c), "R2 R5 coarse", 255'(coarse_sw), therm(c));
         chk((255'(coarse_sw) & prev_c) == prev_c, "R10 coarse monotonic",
             255'(coarse_sw), prev_c);
         prev_c = 255'(coarse_sw);
      end
      // R5 upper data bits ignored
      frame(2'd0, 8'hC5, 10);
      chk(255'(coarse_sw) == therm(5), "R5 upper bits ignored", 255'(coarse_sw), therm(5));

      // R6 medium sweep
      for (int m = 0; m < 64; m++) begin
         frame(2'd1, 8'(m), 10);
         chk(255'(medium_sw) == therm(m), "R6 medium", 255'(medium_sw), therm(m));
      end

      // R7 R10 fine sweep: column/position split
      prev_f = '0;
      for (int f = 0; f < 256; f++) begin
         frame(2'd2, 8'(f), 10);
         chk(fine_sw == therm(f), "R7 fine", fine_sw, therm(f));
         chk((fine_sw & prev_f) == prev_f, "R10 fine monotonic", fine_sw, prev_f);
         prev_f = fine_sw;
      end

      // R3 short and long frames discarded
      prev_c = 255'(coarse_sw);
      frame(2'd0, 8'd40, 9);
      chk(255'(coarse_sw) == prev_c, "R3 short frame", 255'(coarse_sw), prev_c);
      frame(2'd0, 8'd40, 11);
      chk(255'(coarse_sw) == prev_c, "R3 long frame", 255'(coarse_sw), prev_c);

      // R4 no change mid-frame
      prev_m = 255'(medium_sw);
      begin
         logic [9:0] w = {2'd1, 8'd3};
         cfg_cs_n = 1'b0; ticks(3);
         for (int i = 0; i < 10; i++) begin
            bit_out(w[9-i]);
            if (i == 9) ticks(6);
            chk(255'(medium_sw) == prev_m, "R4 mid frame", 255'(medium_sw), prev_m);
         end
         ticks(3); cfg_cs_n = 1'b1; ticks(6);
         chk(255'(medium_sw) == therm(3), "R2 after frame", 255'(medium_sw), therm(3));
      end

      // R11 calibration: zero deviation word, data toggles
      prev_c = 255'(coarse_sw); prev_m = 255'(medium_sw); prev_f = fine_sw;
      frame(2'd3, 8'h00, 10);
      tx_en = 1'b1;
      for (int k = 0; k < 4; k++) begin
         tx_data = k[0]; ticks(1);
         chk(dev_sw == 8'h00, "R11 zero deviation", 255'(dev_sw), '0);
      end

      // R8 deviation keyed by data
      frame(2'd3, 8'hA5, 10);
      chk(255'(coarse_sw) == prev_c && 255'(medium_sw) == prev_m && fine_sw == prev_f,
          "R11 carrier untouched", 255'(coarse_sw), prev_c);
      tx_data = 1'b1; ticks(1);
      chk(dev_sw == 8'hA5, "R8 data one", 255'(dev_sw), 255'(8'hA5));
      tx_data = 1'b0; ticks(1);
      chk(dev_sw == 8'h00, "R8 data zero", 255'(dev_sw), '0);
      frame(2'd3, 8'hFF, 10);
      tx_data = 1'b1; ticks(1);
      chk(dev_sw == 8'hFF, "R8 full word", 255'(dev_sw), 255'(8'hFF));

      // R9 enable low forces zero
      tx_en = 1'b0; ticks(1);
      chk(dev_sw == 8'h00, "R9 tx_en low", 255'(dev_sw), '0);
      tx_data = 1'b0; ticks(1); tx_data = 1'b1; ticks(1);
      chk(dev_sw == 8'h00, "R9 tx_en low data", 255'(dev_sw), '0);
      tx_en = 1'b1; ticks(1);
      chk(dev_sw == 8'hFF, "R9 re-enable", 255'(dev_sw), 255'(8'hFF));
      chk(255'(coarse_sw) == prev_c, "R11 carrier after keying", 255'(coarse_sw), prev_c);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule